// File: doc/BRIEF.md
# Dual-Bus Interrupt Forwarder

This block links two processor buses and handles the interrupt messages that appear on either one. For each incoming interrupt it looks at the redirectable-hint address bit and at the destination ID. From these it sorts the message into one of three classes: a directed interrupt for one processor, a broadcast to every processor, or a redirectable interrupt whose target the block chooses itself. A directed interrupt or a broadcast completes on the bus where it arrived and is copied to the other bus. A redirectable interrupt is re-issued on both buses as a directed message. That message carries a processor ID picked by a round-robin walk over a mask of candidates.

Every interrupt is claimed in the same cycle it is presented, by a target-ready pulse that implies a no-data response. No interrupt is ever deferred. If the queue that would receive the message is full, the request is left unclaimed and the source keeps presenting it. Each bus has an outgoing queue. Its head is shown on the output side with a valid/ready pair. Only one request is taken per cycle, and bus 0 wins a tie.

Top module: `irq_xbus_fwd`

## Requirements
- R1: After reset both outgoing queues are empty (`out_vld` is 0 on both buses) and the round-robin pointer starts at processor ID 0.
- R2: A request is claimed (`in_claim[b]` high) in the same cycle it is presented whenever the queues it needs have room. The claim is the only response given; no request is deferred or answered later.
- R3: A request with `in_hint` = 0 and a destination other than all-ones is a directed interrupt. It places exactly one entry on the other bus's queue, with destination and payload unchanged. It places nothing on its own bus's queue.
- R4: A request with `in_hint` = 0 and destination all-ones (0xFF) is a broadcast. It places one entry on the other bus's queue with destination 0xFF and the payload unchanged.
- R5: A request with `in_hint` = 1 is redirectable. It places one entry on each bus's queue. Both entries carry the same selected destination and the unchanged payload. Every queue entry is a directed message (hint cleared).
- R6: Mask bit i of `rr_mask` enables processor ID i. The redirect target is the first enabled ID found by a cyclic search that starts at the pointer. After the pick, the pointer moves to that ID plus one, modulo NUM_CPU. With an all-zero mask, the incoming destination is kept and the pointer does not move.
- R7: At most one request is claimed per cycle. When both buses can be served, bus 0 is claimed and bus 1 is taken no earlier than the next cycle.
- R8: A directed or broadcast request is not claimed while the other bus's queue holds QDEPTH entries. A redirectable request is not claimed while either queue is full.
- R9: Each queue delivers entries in arrival order. It holds its head stable while `out_rdy` is low and pops on `out_vld && out_rdy`. A push and a pop may happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mask | input | NUM_CPU | Candidate processor IDs for redirection |
| in_req | input | 2 | Interrupt presented, one bit per bus |
| in_hint | input | 2 | Redirectable-hint address bit per bus |
| in_dest | input | 2 x ID_W | Destination ID per bus |
| in_pay | input | 2 x PAY_W | Vector and delivery fields per bus |
| in_claim | output | 2 | Target-ready with no-data response per bus |
| out_vld | output | 2 | Outgoing queue head valid per bus |
| out_dest | output | 2 x ID_W | Outgoing destination ID per bus |
| out_pay | output | 2 x PAY_W | Outgoing vector and delivery fields per bus |
| out_rdy | input | 2 | Bus accepts the queue head |

## Verification
The bench builds the block with NUM_CPU = 8, ID_W = 8, QDEPTH = 4 and a 12-bit payload. The shallow queue lets a run of six directed requests, with `out_rdy` held low, fill a queue and expose the stall at the full boundary. Eight candidates let the cyclic search wrap past ID 7 with sparse masks such as 0xA5 or one single bit. A reference model built from plain queues predicts every claim and queue head in every cycle. This covers tie cycles, zero masks and simultaneous push and pop.

// File: rtl/irqfwd_pkg.sv
package irqfwd_pkg;
  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_DIRECT = 2'd1,
    CLS_BCAST  = 2'd2,
    CLS_REDIR  = 2'd3
  } irq_cls_e;
endpackage

// File: rtl/irq_classify.sv
module irq_classify
  import irqfwd_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            req,
  input  logic            hint,
  input  logic [ID_W-1:0] dest,
  output irq_cls_e        cls
);
  always_comb begin
    if (!req)                 cls = CLS_NONE;
    else if (hint)            cls = CLS_REDIR;
    else if (&dest)           cls = CLS_BCAST;
    else                      cls = CLS_DIRECT;
  end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int NUM_CPU = 8,
  parameter int ID_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] mask,
  input  logic               advance,
  output logic [ID_W-1:0]    pick_id,
  output logic               pick_ok
);
  localparam int PW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic [PW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] pick_idx;

  // cyclic first-set search starting at the pointer
  always_comb begin
    pick_idx = '0;
    pick_ok  = 1'b0;
    for (int k = 0; k < NUM_CPU; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_CPU;
      if (!pick_ok && mask[idx]) begin
        pick_ok  = 1'b1;
        pick_idx = PW'(idx);
      end
    end
  end

  assign pick_id = ID_W'(pick_idx);

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      if (int'(pick_idx) == NUM_CPU - 1) ptr_d = '0;
      else                               ptr_d = pick_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/irq_out_fifo.sv
module irq_out_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         vld,
  output logic [W-1:0] dout,
  input  logic         rdy
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          pop;

  assign vld  = (cnt_q != '0);
  assign full = (cnt_q == (AW+1)'(DEPTH));
  assign dout = mem[rp_q];
  assign pop  = vld && rdy;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + 1'b1;
    if (pop)  rp_d = rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("queue pushed while full");

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !rdy) |=> (vld && $stable(dout))) else $error("queue head moved while stalled");
endmodule

// File: rtl/irq_xbus_fwd.sv
module irq_xbus_fwd
  import irqfwd_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ID_W    = 8,
  parameter int PAY_W   = 16,
  parameter int QDEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CPU-1:0]         rr_mask,
  input  logic [1:0]                 in_req,
  input  logic [1:0]                 in_hint,
  input  logic [1:0][ID_W-1:0]       in_dest,
  input  logic [1:0][PAY_W-1:0]      in_pay,
  output logic [1:0]                 in_claim,
  output logic [1:0]                 out_vld,
  output logic [1:0][ID_W-1:0]       out_dest,
  output logic [1:0][PAY_W-1:0]      out_pay,
  input  logic [1:0]                 out_rdy
);
  localparam int EW = ID_W + PAY_W;

  irq_cls_e          cls [2];
  logic [1:0]        full, room, grant, push;
  logic              sel, redir, advance, pick_ok;
  irq_cls_e          sel_cls;
  logic [ID_W-1:0]   sel_dest, pick_id, push_dest;
  logic [PAY_W-1:0]  sel_pay;
  logic [1:0][EW-1:0] q_dout;

  for (genvar b = 0; b < 2; b++) begin : g_bus
    irq_classify #(.ID_W(ID_W)) u_cls (
      .req  (in_req[b]),
      .hint (in_hint[b]),
      .dest (in_dest[b]),
      .cls  (cls[b])
    );

    always_comb begin
      case (cls[b])
        CLS_REDIR:            room[b] = !full[0] && !full[1];
        CLS_DIRECT, CLS_BCAST: room[b] = !full[1-b];
        default:              room[b] = 1'b0;
      endcase
    end

    // a source bus only receives a copy of its own redirected message
    assign push[b] = (|grant) && (redir || (sel != 1'(b)));

    irq_out_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push[b]),
      .din  ({push_dest, sel_pay}),
      .full (full[b]),
      .vld  (out_vld[b]),
      .dout (q_dout[b]),
      .rdy  (out_rdy[b])
    );

    assign out_dest[b] = q_dout[b][EW-1:PAY_W];
    assign out_pay[b]  = q_dout[b][PAY_W-1:0];

    // R8
    room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_claim[b] && !in_hint[b]) |-> !full[1-b]) else $error("claim without room");
  end

  // fixed priority, bus 0 first
  assign grant[0] = room[0];
  assign grant[1] = room[1] && !room[0];
  assign in_claim = grant;

  assign sel      = grant[1];
  assign sel_cls  = cls[sel];
  assign sel_dest = in_dest[sel];
  assign sel_pay  = in_pay[sel];
  assign redir    = (|grant) && (sel_cls == CLS_REDIR);
  assign advance  = redir && pick_ok;
  assign push_dest = advance ? pick_id : sel_dest;

  irq_rr_pick #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask   (rr_mask),
    .advance(advance),
    .pick_id(pick_id),
    .pick_ok(pick_ok)
  );

  // R7
  one_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_claim)) else $error("two claims in one cycle");

  // R6
  rr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push[0] && in_hint[sel] && (|rr_mask)) |->
      ((int'(push_dest) < NUM_CPU) && rr_mask[push_dest[$clog2(NUM_CPU)-1:0]]))
    else $error("redirect target not enabled");

  // R4
  bcast_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && !in_hint[sel] && (&in_dest[sel])) |-> (&push_dest))
    else $error("broadcast destination altered");

  // R5
  redir_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|in_claim) && in_hint[sel]) |-> (push == 2'b11))
    else $error("redirect not fanned out to both buses");
endmodule

// File: tb/irq_xbus_fwd_bench.sv
module irq_xbus_fwd_bench;
  localparam int NUM_CPU = 8;
  localparam int ID_W    = 8;
  localparam int PAY_W   = 12;
  localparam int QDEPTH  = 4;
  localparam int EW      = ID_W + PAY_W;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [NUM_CPU-1:0]    rr_mask;
  logic [1:0]            in_req, in_hint, in_claim, out_vld, out_rdy;
  logic [1:0][ID_W-1:0]  in_dest, out_dest;
  logic [1:0][PAY_W-1:0] in_pay, out_pay;

  always #5 clk = ~clk;

  irq_xbus_fwd #(.NUM_CPU(NUM_CPU), .ID_W(ID_W), .PAY_W(PAY_W), .QDEPTH(QDEPTH)) u_irq_xbus_fwd (
    .clk(clk), .rst_n(rst_n), .rr_mask(rr_mask),
    .in_req(in_req), .in_hint(in_hint), .in_dest(in_dest), .in_pay(in_pay),
    .in_claim(in_claim), .out_vld(out_vld), .out_dest(out_dest),
    .out_pay(out_pay), .out_rdy(out_rdy)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string tag    = "R1";

  logic [EW-1:0] mq0[$];
  logic [EW-1:0] mq1[$];
  int            rr_ptr = 0;

  function automatic int qsize(input int b);
    return (b == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic bit has_room(input int s);
    if (!in_req[s]) return 0;
    if (in_hint[s]) return (mq0.size() < QDEPTH) && (mq1.size() < QDEPTH);
    return qsize(1 - s) < QDEPTH;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_and_advance();
    bit g0, g1;
    logic [EW-1:0] ent;
    logic [ID_W-1:0] d;
    int s;
    g0 = has_room(0);
    g1 = has_room(1) && !g0;
    check("claim", 32'(in_claim), 32'({g1, g0}));
    check("vld0", 32'(out_vld[0]), 32'(mq0.size() != 0));
    check("vld1", 32'(out_vld[1]), 32'(mq1.size() != 0));
    if (mq0.size() != 0) check("head0", 32'({out_dest[0], out_pay[0]}), 32'(mq0[0]));
    if (mq1.size() != 0) check("head1", 32'({out_dest[1], out_pay[1]}), 32'(mq1[0]));
    if (out_rdy[0] && mq0.size() != 0) void'(mq0.pop_front());
    if (out_rdy[1] && mq1.size() != 0) void'(mq1.pop_front());
    if (g0 || g1) begin
      s = g1 ? 1 : 0;
      d = in_dest[s];
      if (in_hint[s]) begin
        if (rr_mask != 0) begin
          for (int k = 0; k < NUM_CPU; k++) begin
            int idx;
            idx = (rr_ptr + k) % NUM_CPU;
            if (rr_mask[idx]) begin
              d = ID_W'(idx);
              rr_ptr = (idx + 1) % NUM_CPU;
              break;
            end
          end
        end
        ent = {d, in_pay[s]};
        mq0.push_back(ent);
        mq1.push_back(ent);
      end else begin
        ent = {d, in_pay[s]};
        if (s == 0) mq1.push_back(ent);
        else        mq0.push_back(ent);
      end
    end
  endtask

  task automatic step();
    #1;
    compare_and_advance();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int b, input bit v, input bit h, input logic [7:0] d, input logic [11:0] p);
    in_req[b]  = v;
    in_hint[b] = h;
    in_dest[b] = d;
    in_pay[b]  = p;
  endtask

  task automatic idle();
    in_req = 2'b00;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rr_mask = 8'hFF;
    in_req = 0; in_hint = 0; in_dest = 0; in_pay = 0;
    out_rdy = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty queues after reset
    tag = "R1";
    step();

    // R3: directed from each bus, forwarded unchanged to the other bus
    tag = "R3";
    drive(0, 1, 0, 8'h12, 12'h3A5); step();
    idle(); step();
    drive(1, 1, 0, 8'h07, 12'h0C3); step();
    idle(); step(); step();

    // R4: broadcast keeps all-ones destination
    tag = "R4";
    drive(0, 1, 0, 8'hFF, 12'h111); step();
    idle();
    drive(1, 1, 0, 8'hFF, 12'h222); step();
    idle(); step(); step();

    // R5 and R6: redirect fan-out and round-robin over masks
    tag = "R5";
    drive(0, 1, 1, 8'h44, 12'hABC); step();
    idle(); step(); step();
    tag = "R6";
    rr_mask = 8'hA5;
    for (int i = 0; i < 6; i++) begin
      drive(i % 2, 1, 1, 8'h30, 12'(i)); step();
      idle(); step();
    end
    rr_mask = 8'h01;
    drive(1, 1, 1, 8'h55, 12'h777); step();
    idle(); step();
    rr_mask = 8'h00;
    drive(0, 1, 1, 8'h5B, 12'h888); step();
    idle(); step(); step();
    rr_mask = 8'hFF;

    // R7: simultaneous requests, bus 0 first
    tag = "R7";
    drive(0, 1, 0, 8'h01, 12'h101);
    drive(1, 1, 0, 8'h02, 12'h202); step();
    in_req[0] = 0; step();
    idle(); step(); step();

    // R8: fill a queue with out_rdy low, claims stop at the boundary
    tag = "R8";
    out_rdy = 2'b00;
    for (int i = 0; i < 6; i++) begin
      drive(0, 1, 0, 8'(8'h20 + i), 12'(12'h500 + i)); step();
    end
    drive(0, 0, 0, 0, 0);
    drive(1, 1, 1, 8'h10, 12'h9AA); step();
    idle();

    // R9: drain in order, then push and pop together
    tag = "R9";
    out_rdy = 2'b10; step(); step();
    drive(0, 1, 0, 8'h66, 12'h660); step();
    idle();
    out_rdy = 2'b11;
    repeat (6) step();

    // R2: mixed traffic with random back-pressure
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < 2; b++) begin
        logic [7:0] d;
        d = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
        drive(b, ($urandom % 2) == 0, ($urandom % 3) == 0, d, 12'($urandom));
      end
      out_rdy = 2'($urandom % 4 != 0 ? 2'b11 : $urandom);
      if (i % 97 == 0) rr_mask = ($urandom % 5 == 0) ? 8'h00 : 8'($urandom);
      step();
    end
    idle(); out_rdy = 2'b11;
    repeat (8) step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule